// File: doc/BRIEF.md
# Dual-Format Signed Adder/Subtractor

This combinational unit adds or subtracts two 8-bit signed operands. Both operands arrive in signed-magnitude form. The unit computes the same operation in two arithmetic systems side by side. One path works on magnitudes and signs. The other path converts each operand to two's complement and uses a ripple-carry adder. Each path has its own result and its own overflow flag, and all four outputs settle in the same evaluation.

The signed-magnitude path first finds the effective sign of the second operand, which flips when subtracting. If the signs match, it adds the magnitudes and keeps the common sign. If they differ, it subtracts the smaller magnitude from the larger and takes the sign of the larger operand. The two's-complement path subtracts by inverting the converted second operand and setting the carry-in. Either path may overflow. In that case its result is the wrapped value in its own format.

Top module: `dfa_addsub_dual`

## Requirements
- R1: Signed-magnitude values, at the inputs and at `sm_sum_o`, carry the sign in bit 7 (1 = negative) and the magnitude in bits 6:0; for example -117 is 0xF5 and -89 is 0xD9.
- R2: `tc_sum_o` is the low 8 bits of the two's-complement sum of the converted operands, where a negative value is the inverted positive value plus one (-117 = 0x8B, -89 = 0xA7); 117 + (-89) gives 0x1C and -117 + 89 gives 0xE4.
- R3: With `sub_i` = 1 both paths compute opa - opb by adding the negated second operand; with `sub_i` = 0 they compute opa + opb.
- R4: `tc_ovf_o` is 1 exactly when the carry into bit 7 differs from the carry out of bit 7, i.e. when the true result lies outside -128..127.
- R5: `sm_ovf_o` is 1 exactly when the effective signs match and the magnitude sum exceeds 127; the result then holds the sum modulo 128 with the common sign.
- R6: When the effective signs differ, `sm_sum_o` has magnitude |larger| - |smaller| and the sign of the larger-magnitude operand, and `sm_ovf_o` is 0.
- R7: A zero signed-magnitude result is always 0x00, never 0x80. This holds for negative-zero inputs and for a wrapped magnitude of zero.
- R8: Both results and both flags are valid together. For example, 117 - (-89) gives `tc_sum_o` = 0xCE with `tc_ovf_o` = 1 and `sm_sum_o` = 0x4E with `sm_ovf_o` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 8 | First operand, signed magnitude |
| opb_i | input | 8 | Second operand, signed magnitude |
| sub_i | input | 1 | 1 selects subtraction, 0 addition |
| sm_sum_o | output | 8 | Result in signed magnitude |
| sm_ovf_o | output | 1 | Signed-magnitude overflow |
| tc_sum_o | output | 8 | Result in two's complement |
| tc_ovf_o | output | 1 | Two's-complement overflow |

## Verification
Both overflow detectors can fire on the same operation. That happens when two large same-sign operands are added, or when a positive operand has a large negative one subtracted from it. The bench sweeps every operand pair under both operation selects, so every way the two flags can combine is covered, including sums that wrap to exactly zero. For each vector it computes the true integer result and derives both expected encodings and both flags from that range. When neither flag is set, the checker also requires that the two results denote the same value.

// File: rtl/dfa_pkg.sv
package dfa_pkg;
  localparam int unsigned DFA_W = 8;
  localparam int unsigned DFA_MW = DFA_W - 1;
endpackage

// File: rtl/dfa_sm_to_tc.sv
module dfa_sm_to_tc #(
  parameter int W = dfa_pkg::DFA_W
) (
  input  logic [W-1:0] sm_i,
  output logic [W-1:0] tc_o
);
  localparam int MW = W - 1;

  function automatic logic [W-1:0] negate(input logic [W-1:0] v);
    negate = ~v + {{MW{1'b0}}, 1'b1};
  endfunction

  logic [W-1:0] mag_ext;
  assign mag_ext = {1'b0, sm_i[MW-1:0]};
  assign tc_o = sm_i[W-1] ? negate(mag_ext) : mag_ext;
endmodule

// File: rtl/dfa_ripple_add.sv
module dfa_ripple_add #(
  parameter int W = dfa_pkg::DFA_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         c_msb_in_o,
  output logic         c_msb_out_o
);
  logic [W:0] carry;
  assign carry[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i]     = a_i[i] ^ b_i[i] ^ carry[i];
    assign carry[i + 1] = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
  end

  assign c_msb_in_o  = carry[W-1];
  assign c_msb_out_o = carry[W];
endmodule

// File: rtl/dfa_sm_unit.sv
module dfa_sm_unit #(
  parameter int W = dfa_pkg::DFA_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         ovf_o,
  output logic         same_sign_o
);
  localparam int MW = W - 1;

  function automatic logic [MW-1:0] mag_diff(input logic [MW-1:0] x, input logic [MW-1:0] y);
    mag_diff = (x >= y) ? (x - y) : (y - x);
  endfunction

  logic          a_s, b_s, a_ge, sgn;
  logic [MW-1:0] am, bm, mag;
  logic [MW:0]   mag_sum;

  assign a_s  = a_i[W-1];
  assign b_s  = b_i[W-1] ^ sub_i;
  assign am   = a_i[MW-1:0];
  assign bm   = b_i[MW-1:0];
  assign a_ge = (am >= bm);

  assign mag_sum     = {1'b0, am} + {1'b0, bm};
  assign same_sign_o = (a_s == b_s);

  always_comb begin
    if (same_sign_o) begin
      mag = mag_sum[MW-1:0];
      sgn = a_s;
    end else begin
      mag = mag_diff(am, bm);
      sgn = a_ge ? a_s : b_s;
    end
  end

  assign res_o = {sgn & (|mag), mag};
  assign ovf_o = same_sign_o & mag_sum[MW];
endmodule

// File: rtl/dfa_addsub_dual.sv
module dfa_addsub_dual #(
  parameter int W = dfa_pkg::DFA_W
) (
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         sub_i,
  output logic [W-1:0] sm_sum_o,
  output logic         sm_ovf_o,
  output logic [W-1:0] tc_sum_o,
  output logic         tc_ovf_o
);
  logic [W-1:0] tc_a_w, tc_b_w, tc_b_eff_w;
  logic         same_sign_w, c_into_sign_w, c_out_sign_w;

  dfa_sm_to_tc #(.W(W)) u_conv_a (.sm_i(opa_i), .tc_o(tc_a_w));
  dfa_sm_to_tc #(.W(W)) u_conv_b (.sm_i(opb_i), .tc_o(tc_b_w));

  assign tc_b_eff_w = sub_i ? ~tc_b_w : tc_b_w;

  dfa_ripple_add #(.W(W)) u_tc_add (
    .a_i(tc_a_w), .b_i(tc_b_eff_w), .cin_i(sub_i),
    .sum_o(tc_sum_o), .c_msb_in_o(c_into_sign_w), .c_msb_out_o(c_out_sign_w)
  );
  assign tc_ovf_o = c_into_sign_w ^ c_out_sign_w;

  dfa_sm_unit #(.W(W)) u_sm (
    .a_i(opa_i), .b_i(opb_i), .sub_i(sub_i),
    .res_o(sm_sum_o), .ovf_o(sm_ovf_o), .same_sign_o(same_sign_w)
  );
endmodule

// File: rtl/dfa_addsub_dual_chk.sv
module dfa_addsub_dual_chk #(
  parameter int W = dfa_pkg::DFA_W
) (
  input logic [W-1:0] tc_a,
  input logic [W-1:0] tc_b_eff,
  input logic         same_sign,
  input logic [W-1:0] sm_sum,
  input logic         sm_ovf,
  input logic [W-1:0] tc_sum,
  input logic         tc_ovf
);
  localparam int MW = W - 1;
  int sm_val;

  always_comb begin
    sm_val = sm_sum[W-1] ? -int'(sm_sum[MW-1:0]) : int'(sm_sum[MW-1:0]);
    p_sm_zero_pos_r7: assert ((sm_sum[MW-1:0] != '0) || !sm_sum[W-1])
      else $error("negative zero on signed-magnitude result");
    p_sm_ovf_same_r5: assert (!sm_ovf || same_sign)
      else $error("signed-magnitude overflow with differing signs");
    p_no_overflow_r6: assert (same_sign || !sm_ovf)
      else $error("overflow flagged on differing-sign operation");
    p_tc_ovf_signs_r4: assert (tc_ovf == ((tc_a[W-1] == tc_b_eff[W-1]) && (tc_sum[W-1] != tc_a[W-1])))
      else $error("two's-complement overflow disagrees with operand signs");
    p_formats_agree_r8: assert (sm_ovf || tc_ovf || (sm_val == int'($signed(tc_sum))))
      else $error("formats disagree without overflow");
  end
endmodule

bind dfa_addsub_dual dfa_addsub_dual_chk #(.W(W)) u_chk (
  .tc_a(tc_a_w), .tc_b_eff(tc_b_eff_w), .same_sign(same_sign_w),
  .sm_sum(sm_sum_o), .sm_ovf(sm_ovf_o), .tc_sum(tc_sum_o), .tc_ovf(tc_ovf_o)
);

// File: tb/sim_dfa_addsub_dual.sv
`timescale 1ns/1ps
module sim_dfa_addsub_dual;
  logic       clk = 1'b0;
  logic [7:0] opa, opb, sm_sum, tc_sum;
  logic       sub, sm_ovf, tc_ovf;
  int         checks = 0, errors = 0, cycles = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  dfa_addsub_dual u0 (
    .opa_i(opa), .opb_i(opb), .sub_i(sub),
    .sm_sum_o(sm_sum), .sm_ovf_o(sm_ovf), .tc_sum_o(tc_sum), .tc_ovf_o(tc_ovf)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h sub=%0d actual=%h expected=%h", tag, opa, opb, sub, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic s);
    opa = a; opb = b; sub = s;
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    apply(8'h00, 8'h00, 1'b0);
    chk("R7 idle sm", sm_sum, 8'h00);
    chk("R7 idle tc", tc_sum, 8'h00);
    chk("R8 idle flags", {sm_ovf, tc_ovf}, 0);

    apply(8'h75, 8'hD9, 1'b0);  // 117 + (-89)
    chk("R2 tc 117+-89", tc_sum, 8'h1C);
    chk("R6 sm 117+-89", sm_sum, 8'h1C);
    apply(8'hF5, 8'h59, 1'b0);  // -117 + 89
    chk("R2 tc -117+89", tc_sum, 8'hE4);
    chk("R6 sm -117+89", sm_sum, 8'h9C);
    apply(8'h75, 8'hD9, 1'b1);  // 117 - (-89)
    chk("R8 tc 117--89", tc_sum, 8'hCE);
    chk("R8 flags 117--89", {sm_ovf, tc_ovf}, 3);
    chk("R5 sm 117--89", sm_sum, 8'h4E);
    apply(8'h80, 8'h00, 1'b0);  // -0 + 0
    chk("R7 negzero", sm_sum, 8'h00);
    apply(8'h40, 8'h40, 1'b0);  // 64 + 64 wraps to 0
    chk("R7 wrapped zero", sm_sum, 8'h00);
    chk("R4 tc 64+64", {tc_sum, tc_ovf}, {8'h80, 1'b1});
    apply(8'h05, 8'h89, 1'b0);  // 5 + (-9)
    chk("R6 sm 5+-9", {sm_sum, sm_ovf}, {8'h84, 1'b0});
    apply(8'h05, 8'h09, 1'b1);  // 5 - 9
    chk("R3 sub 5-9", {sm_sum, tc_sum}, {8'h84, 8'hFC});

    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          int av, bv, r, ar, m;
          logic [7:0] ua, ub, exp_sm;
          ua = a[7:0]; ub = b[7:0];
          apply(ua, ub, s[0]);
          av = ua[7] ? -int'(ua[6:0]) : int'(ua[6:0]);
          bv = ub[7] ? -int'(ub[6:0]) : int'(ub[6:0]);
          r  = (s == 1) ? av - bv : av + bv;
          ar = (r < 0) ? -r : r;
          m  = ar % 128;
          exp_sm = {((r < 0) && (m != 0)), m[6:0]};
          chk((s == 1) ? "R3 tc sum" : "R2 tc sum", tc_sum, r[7:0]);
          chk("R4 tc ovf", tc_ovf, (r > 127 || r < -128) ? 1 : 0);
          chk("R5 sm ovf", sm_ovf, (ar > 127) ? 1 : 0);
          if (r == 0)       chk("R7 sm zero", sm_sum, exp_sm);
          else if (ar > 127) chk("R5 sm wrap", sm_sum, exp_sm);
          else if ((av < 0) != ((s == 1) ? (bv > 0) : (bv < 0)))
                            chk("R6 sm diff", sm_sum, exp_sm);
          else              chk("R1 sm sum", sm_sum, exp_sm);
        end
      end
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule